// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Parallel Controller

This controller sits in programmable logic next to a six-channel simultaneous-sampling converter that has a parallel bus. A start request carries a three-bit group mask. The controller issues a low-then-high conversion-start pulse on the strobe of each enabled group, all in the same cycles. Group 0 covers channels 0 and 1, group 1 covers channels 2 and 3, and group 2 covers channels 4 and 5. The controller then waits for the converter's busy line to fall. If busy does not fall in time, it gives up and raises an error pulse.

Once conversion ends, the controller reads each converted channel with chip-select and read-strobe cycles, taking the channels in ascending order. Each result leaves the block as a single beat that carries a channel tag. A mode bit selects whole-word reads or two byte reads per result. Every pulse width and gap is a parameter counted in system clocks, so the block works at any clock frequency. The block also enforces the converter's acquisition time before the next sampling edge.

Top module: `simsamp_adc_ctrl`

## Requirements
- R1: A start request with a nonzero mask drives each enabled strobe low for at least STROBE_LO_CYC clocks and then high. All enabled strobes rise together. Strobes of disabled groups stay high.
- R2: Mask bit g maps to strobe conv_n[g]. Groups are sampled exactly as the mask asks, and only those groups.
- R3: cs_n and rd_n stay high from the start pulse until the controller has seen busy fall. No read happens while busy is high.
- R4: If busy has not fallen BUSY_TIMEOUT_CYC clocks after the strobe rises, timeout_err pulses high for one clock. No read cycle follows, and the controller returns to idle.
- R5: A read cycle holds rd_n and cs_n low together for exactly RD_LO_CYC clocks, and the bus is sampled inside that window. Between two reads, cs_n stays high for at least RD_GAP_CYC clocks.
- R6: With byte_mode=0, each result takes one read, and out_data equals the 16-bit bus value.
- R7: With byte_mode=1, each result takes two reads, each taking a byte from bus_in[7:0]. With HIGH_FIRST=1 (the default), the first byte read is bits 15:8 of the result and the second is bits 7:0.
- R8: Each result appears once as a one-clock out_valid beat, with out_chan set to the channel index 0..5. Channels come out in ascending order. Only channels of converted groups appear.
- R9: A strobe rises no sooner than ACQ_CYC clocks after the previous busy fall.
- R10: start_req is ignored while a conversion or readout is in progress. A start request with mask 0 is ignored as well.
- R11: Out of reset, conv_n=3'b111, cs_n=1, rd_n=1, out_valid=0 and timeout_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Conversion request, sampled while idle |
| grp_mask | input | 3 | Channel-pair groups to convert |
| byte_mode | input | 1 | 0 = word reads, 1 = byte reads |
| conv_n | output | 3 | Per-group conversion-start strobes, active low |
| busy | input | 1 | Converter busy, asynchronous |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_in | input | 16 | Converter data bus |
| out_valid | output | 1 | Result beat valid |
| out_chan | output | 3 | Channel index of the beat |
| out_data | output | 16 | Conversion result |
| timeout_err | output | 1 | One-clock pulse when busy never falls |

## Verification
The bench starts the next conversion soon after the last readout ends, so the acquisition guard has to hold the strobe. A design that measured the guard from the wrong event, or skipped it, would raise the strobe early. The bench changes the upper bus byte in byte mode and swaps the byte order. A design that masked the bytes wrongly or assembled them in the wrong order would emit corrupted results. The bench pulses start_req again in the middle of a conversion and also issues a start with an empty mask; a design that accepted either would issue extra strobes or extra beats. Finally, the bench holds busy high until the timeout fires. A design without a working timeout would hang or would read during conversion.

// File: rtl/simsamp_pkg.sv
// Shared types and constants for the simultaneous-sampling ADC controller.
// Assumes three strobe groups of two channels each.
package simsamp_pkg;
    localparam int GROUPS   = 3;
    localparam int CHANS    = 2 * GROUPS;
    localparam int CH_IDX_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_CONV,
        ST_RD_LO,
        ST_RD_GAP
    } ctl_state_t;
endpackage

// File: rtl/simsamp_cnt.sv
// Loadable down counter used for every timed phase.
// Assumes load has priority; done is high while the count is zero.
module simsamp_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count down toward zero, or reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/simsamp_chan_pick.sv
// Picks the lowest-numbered pending channel.
// Assumes the pending vector is one bit per channel.
module simsamp_chan_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Priority encoder: the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/simsamp_byte_join.sv
// Holds the first byte of a byte-mode result and joins it with the second.
// Assumes take fires once per read; second marks the second read of a pair.
module simsamp_byte_join #(
    parameter bit HIGH_FIRST = 1'b1,
    parameter int BW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          second,
    input  logic [BW-1:0] byte_in,
    output logic [2*BW-1:0] word_out
);
    logic [BW-1:0] held;

    // Keep the first byte of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                held <= '0;
        else if (take && !second)  held <= byte_in;
    end

    // Order the two bytes by the parameter.
    generate
        if (HIGH_FIRST) begin : g_hi_first
            assign word_out = {held, byte_in};
        end else begin : g_lo_first
            assign word_out = {byte_in, held};
        end
    endgenerate
endmodule

// File: rtl/simsamp_adc_ctrl.sv
// Top-level controller: strobes the enabled groups, waits for busy to fall
// (with a timeout), then reads the converted channels in ascending order.
// Assumes busy is asynchronous (synchronised here) and that the bus is
// valid during the last clock of each read-strobe window.
module simsamp_adc_ctrl
    import simsamp_pkg::*;
#(
    parameter int  DATA_W           = 16,
    parameter int  STROBE_LO_CYC    = 4,
    parameter int  ACQ_CYC          = 110,
    parameter int  RD_LO_CYC        = 3,
    parameter int  RD_GAP_CYC       = 2,
    parameter int  BUSY_TIMEOUT_CYC = 800,
    parameter bit  HIGH_FIRST       = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic [GROUPS-1:0]   grp_mask,
    input  logic                byte_mode,
    output logic [GROUPS-1:0]   conv_n,
    input  logic                busy,
    output logic                cs_n,
    output logic                rd_n,
    input  logic [DATA_W-1:0]   bus_in,
    output logic                out_valid,
    output logic [CH_IDX_W-1:0] out_chan,
    output logic [DATA_W-1:0]   out_data,
    output logic                timeout_err
);
    localparam int M1   = (STROBE_LO_CYC > RD_LO_CYC) ? STROBE_LO_CYC : RD_LO_CYC;
    localparam int M2   = (M1 > RD_GAP_CYC) ? M1 : RD_GAP_CYC;
    localparam int PH_MAX = (M2 > BUSY_TIMEOUT_CYC) ? M2 : BUSY_TIMEOUT_CYC;
    localparam int PH_W = $clog2(PH_MAX + 1);
    localparam int AQ_W = $clog2(ACQ_CYC + 1);
    localparam int BW   = DATA_W / 2;

    ctl_state_t          state;
    logic [GROUPS-1:0]   mask_q;
    logic                mode_q;
    logic [CHANS-1:0]    pend;
    logic [CHANS-1:0]    mask_exp;
    logic                half;
    logic [1:0]          busy_sync;
    logic                busy_prev;
    logic                busy_fall;
    logic                ph_load, ph_done;
    logic [PH_W-1:0]     ph_val;
    logic                aq_load, aq_done;
    logic [CH_IDX_W-1:0] pick_idx;
    logic                pick_any;
    logic                start_ok;
    logic                rd_take;
    logic [DATA_W-1:0]   join_word;

    // Bring busy into the clock domain and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_sync <= 2'b00;
            busy_prev <= 1'b0;
        end else begin
            busy_sync <= {busy_sync[0], busy};
            busy_prev <= busy_sync[1];
        end
    end
    assign busy_fall = busy_prev & ~busy_sync[1];

    // Widen the group mask to one bit per channel.
    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            mask_exp[2*g]   = grp_mask[g];
            mask_exp[2*g+1] = grp_mask[g];
        end
    end

    assign start_ok = (state == ST_IDLE) && start_req && (|grp_mask);
    assign rd_take  = (state == ST_RD_LO) && ph_done;

    // Choose when the phase and acquisition timers reload, and with what value.
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        aq_load = 1'b0;
        unique case (state)
            ST_IDLE: if (start_ok) begin
                ph_load = 1'b1;
                ph_val  = PH_W'(STROBE_LO_CYC - 1);
            end
            ST_STROBE: if (ph_done && aq_done) begin
                ph_load = 1'b1;
                ph_val  = PH_W'(BUSY_TIMEOUT_CYC - 1);
            end
            ST_CONV: if (busy_fall) begin
                ph_load = 1'b1;
                ph_val  = PH_W'(RD_LO_CYC - 1);
                aq_load = 1'b1;
            end else if (ph_done) begin
                aq_load = 1'b1;
            end
            ST_RD_LO: if (ph_done) begin
                ph_load = 1'b1;
                ph_val  = PH_W'(RD_GAP_CYC - 1);
            end
            ST_RD_GAP: if (ph_done && pick_any) begin
                ph_load = 1'b1;
                ph_val  = PH_W'(RD_LO_CYC - 1);
            end
            default: ;
        endcase
    end

    simsamp_cnt #(.W(PH_W)) i_ph_cnt (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    simsamp_cnt #(.W(AQ_W)) i_aq_cnt (
        .clk(clk), .rst_n(rst_n), .load(aq_load), .load_val(AQ_W'(ACQ_CYC)), .done(aq_done)
    );

    simsamp_chan_pick #(.N(CHANS), .IW(CH_IDX_W)) i_pick (
        .pend(pend), .idx(pick_idx), .any(pick_any)
    );

    simsamp_byte_join #(.HIGH_FIRST(HIGH_FIRST), .BW(BW)) i_join (
        .clk(clk), .rst_n(rst_n), .take(rd_take && mode_q), .second(half),
        .byte_in(bus_in[BW-1:0]), .word_out(join_word)
    );

    // Main sequencer: strobe, wait for busy, read, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            mask_q      <= '0;
            mode_q      <= 1'b0;
            pend        <= '0;
            half        <= 1'b0;
            out_valid   <= 1'b0;
            out_chan    <= '0;
            out_data    <= '0;
            timeout_err <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_ok) begin
                    mask_q <= grp_mask;
                    mode_q <= byte_mode;
                    pend   <= mask_exp;
                    half   <= 1'b0;
                    state  <= ST_STROBE;
                end
                ST_STROBE: if (ph_done && aq_done) state <= ST_CONV;
                ST_CONV: begin
                    if (busy_fall) begin
                        state <= ST_RD_LO;
                    end else if (ph_done) begin
                        timeout_err <= 1'b1;
                        pend        <= '0;
                        state       <= ST_IDLE;
                    end
                end
                ST_RD_LO: if (ph_done) begin
                    state <= ST_RD_GAP;
                    if (!mode_q) begin
                        out_valid      <= 1'b1;
                        out_chan       <= pick_idx;
                        out_data       <= bus_in;
                        pend[pick_idx] <= 1'b0;
                    end else if (!half) begin
                        half <= 1'b1;
                    end else begin
                        out_valid      <= 1'b1;
                        out_chan       <= pick_idx;
                        out_data       <= join_word;
                        pend[pick_idx] <= 1'b0;
                        half           <= 1'b0;
                    end
                end
                ST_RD_GAP: if (ph_done) state <= pick_any ? ST_RD_LO : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign conv_n = (state == ST_STROBE) ? ~mask_q : {GROUPS{1'b1}};
    assign cs_n   = (state != ST_RD_LO);
    assign rd_n   = (state != ST_RD_LO);

    // R2: only groups of the latched mask may be strobed.
    a_r2_strobe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_n != 3'b111) |-> ((~conv_n & ~mask_q) == 3'b000));

    // R3: no bus access before busy has fallen.
    a_r3_no_read_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV || state == ST_STROBE) |-> (cs_n && rd_n));

    // R9: strobe may not rise while the acquisition window is open.
    a_r9_hold_for_acq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !aq_done) |=> (conv_n == $past(conv_n)));

    // R4: after an error the controller is idle.
    a_r4_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (state == ST_IDLE && cs_n));

    // R8: every beat names a channel of a converted group.
    a_r8_chan_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan < 3'd6 && mask_q[out_chan[2:1]]));
endmodule

// File: tb/test_simsamp_adc_ctrl.sv
// Bench: converter model, vector table walk, then directed corner cases.
module test_simsamp_adc_ctrl;
    localparam int STROBE_LO_CYC = 4;
    localparam int ACQ_CYC       = 110;
    localparam int RD_LO_CYC     = 3;
    localparam int RD_GAP_CYC    = 2;
    localparam int BT_CYC        = 800;
    localparam int CONV_T        = 600;
    localparam int NVEC          = 8;
    // entry: {mask[2:0], byte_mode}
    localparam logic [3:0] VEC [NVEC] = '{4'b1110, 4'b1111, 4'b0010, 4'b0101,
                                          4'b1000, 4'b1011, 4'b0110, 4'b1101};

    logic clk = 1'b0;
    logic rst_n, start_req, byte_mode, busy;
    logic [2:0] grp_mask, conv_n, out_chan;
    logic cs_n, rd_n, out_valid, timeout_err;
    logic [15:0] out_data, drv;
    wire  [15:0] dbus;

    int checks = 0, errors = 0, cyc = 0;
    bit stuck = 0;
    logic [2:0] exp_mask = 3'b000;
    logic [5:0] rem_ch, exp_rem;
    int seq, busy_cnt, last_fall, conv_count, beats, reads, err_cnt, rise_cyc, err_cyc;
    bit half_m, fell_once;
    int lo_run [3];
    int rd_lo_run, cs_hi_run;
    logic [2:0] prev_conv;
    logic prev_rd, prev_cs;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    simsamp_adc_ctrl i_simsamp_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .grp_mask(grp_mask),
        .byte_mode(byte_mode), .conv_n(conv_n), .busy(busy), .cs_n(cs_n),
        .rd_n(rd_n), .bus_in(dbus), .out_valid(out_valid), .out_chan(out_chan),
        .out_data(out_data), .timeout_err(timeout_err)
    );

    function automatic logic [15:0] val(int s, int ch);
        return 16'((s * 305 + ch * 8707) ^ 16'h5A5A);
    endfunction

    function automatic int low_ch(logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return 6;
    endfunction

    function automatic logic [5:0] widen(logic [2:0] m);
        return {{2{m[2]}}, {2{m[1]}}, {2{m[0]}}};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter bus: driven only while chip select and read are both low.
    always_comb begin
        logic [15:0] v;
        v = val(seq, low_ch(rem_ch));
        drv = byte_mode ? {8'hEE, (half_m ? v[7:0] : v[15:8])} : v;
    end
    assign dbus = (!cs_n && !rd_n) ? drv : 16'hzzzz;

    // Converter model and protocol monitors, evaluated on falling edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 0; busy_cnt = 0; seq = 0; rem_ch = 0; exp_rem = 0; half_m = 0;
            fell_once = 0; last_fall = 0; conv_count = 0; beats = 0; reads = 0;
            err_cnt = 0; rise_cyc = 0; err_cyc = 0; rd_lo_run = 0; cs_hi_run = 0;
            prev_conv = 3'b111; prev_rd = 1; prev_cs = 1;
            for (int g = 0; g < 3; g++) lo_run[g] = 0;
        end else begin
            logic [2:0] rises;
            rises = ~prev_conv & conv_n;
            for (int g = 0; g < 3; g++) begin
                if (rises[g]) chk(lo_run[g] >= STROBE_LO_CYC, "R1 strobe low width", lo_run[g], STROBE_LO_CYC);
                lo_run[g] = conv_n[g] ? 0 : lo_run[g] + 1;
            end
            if (rises != 0) begin
                chk(rises == exp_mask, "R2 strobed groups", rises, exp_mask);
                if (fell_once) chk(cyc - last_fall >= ACQ_CYC, "R9 acquisition gap", cyc - last_fall, ACQ_CYC);
                if (!busy) begin
                    busy = 1; busy_cnt = 0; seq++; conv_count++;
                    rem_ch = widen(rises); exp_rem = widen(exp_mask); half_m = 0;
                    rise_cyc = cyc;
                end
            end else if (busy) begin
                busy_cnt++;
                if (!stuck && busy_cnt >= CONV_T) begin
                    busy = 0; last_fall = cyc; fell_once = 1;
                end
            end
            if (!rd_n && prev_rd) begin
                reads++;
                chk(!busy && !cs_n, "R3 read only after busy fell, with cs", busy, 0);
                chk(cs_hi_run >= RD_GAP_CYC, "R5 gap between reads", cs_hi_run, RD_GAP_CYC);
            end
            if (rd_n && !prev_rd) begin
                chk(rd_lo_run == RD_LO_CYC, "R5 read strobe width", rd_lo_run, RD_LO_CYC);
                if (byte_mode && !half_m) half_m = 1;
                else begin
                    rem_ch[low_ch(rem_ch)] = 1'b0; half_m = 0;
                end
            end
            rd_lo_run = rd_n ? 0 : rd_lo_run + 1;
            cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
            if (out_valid) begin
                int ech;
                ech = low_ch(exp_rem);
                beats++;
                chk(out_chan == 3'(ech), "R8 channel order", out_chan, ech);
                chk(out_data == val(seq, ech), byte_mode ? "R7 byte result" : "R6 word result",
                    out_data, val(seq, ech));
                if (ech < 6) exp_rem[ech] = 1'b0;
            end
            if (timeout_err) begin
                err_cnt++; err_cyc = cyc;
                chk(stuck, "R4 error only when busy stays high", 0, 1);
            end
            prev_conv = conv_n; prev_rd = rd_n; prev_cs = cs_n;
        end
    end

    task automatic run_one(logic [2:0] m, logic b);
        int b0, r0, tgt, t;
        b0 = beats; r0 = reads;
        tgt = $countones(m) * 2;
        exp_mask = m; grp_mask = m; byte_mode = b; start_req = 1;
        @(negedge clk); start_req = 0;
        t = 0;
        while (beats - b0 < tgt && t < 3000) begin @(negedge clk); t++; end
        repeat (12) @(negedge clk);
        chk(beats - b0 == tgt, "R8 beat count", beats - b0, tgt);
        chk(reads - r0 == tgt * (b ? 2 : 1), b ? "R7 two reads per result" : "R6 one read per result",
            reads - r0, tgt * (b ? 2 : 1));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b0, c0, r0, e0;
        rst_n = 0; start_req = 0; grp_mask = 0; byte_mode = 0;
        repeat (5) @(negedge clk);
        chk(conv_n == 3'b111, "R11 reset strobes", conv_n, 7);
        chk(cs_n && rd_n, "R11 reset bus control", {cs_n, rd_n}, 3);
        chk(!out_valid && !timeout_err, "R11 reset outputs", {out_valid, timeout_err}, 0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: each entry runs soon after the last, exercising R9.
        for (int i = 0; i < NVEC; i++) run_one(VEC[i][3:1], VEC[i][0]);

        // R10: a second start during conversion is ignored.
        b0 = beats; c0 = conv_count;
        exp_mask = 3'b001; grp_mask = 3'b001; byte_mode = 0; start_req = 1;
        @(negedge clk); start_req = 0;
        repeat (100) @(negedge clk);
        grp_mask = 3'b111; start_req = 1;
        @(negedge clk); start_req = 0;
        repeat (900) @(negedge clk);
        chk(beats - b0 == 2, "R10 start ignored while busy (beats)", beats - b0, 2);
        chk(conv_count - c0 == 1, "R10 start ignored while busy (conversions)", conv_count - c0, 1);

        // R10: empty mask does nothing.
        c0 = conv_count; b0 = beats;
        grp_mask = 3'b000; start_req = 1;
        @(negedge clk); start_req = 0;
        repeat (200) @(negedge clk);
        chk(conv_count == c0 && beats == b0, "R10 empty mask ignored", conv_count - c0, 0);

        // R4: busy never falls.
        r0 = reads; e0 = err_cnt; stuck = 1;
        exp_mask = 3'b010; grp_mask = 3'b010; start_req = 1;
        @(negedge clk); start_req = 0;
        repeat (1200) @(negedge clk);
        chk(err_cnt - e0 == 1, "R4 timeout pulse", err_cnt - e0, 1);
        chk(reads == r0, "R4 no reads after timeout", reads - r0, 0);
        chk(err_cyc - rise_cyc >= BT_CYC && err_cyc - rise_cyc <= BT_CYC + 2,
            "R4 timeout delay", err_cyc - rise_cyc, BT_CYC);
        stuck = 0;
        repeat (ACQ_CYC + 20) @(negedge clk);

        // Recovery after the timeout, byte mode, all groups.
        run_one(3'b111, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule